// File: doc/BRIEF.md
# I2C Channel Configuration Target

This block is a write-only I2C target that holds one configuration byte for each of three independent channels. An external controller addresses it over SCL and SDA, names a channel through a subaddress byte and then sends exactly one data byte for that channel. The block answers every byte with an ACK or a NACK by pulling SDA low through an open-drain enable. Only one register changes per transaction, so writing all three channels takes three separate START-to-STOP transactions.

The two low bits of the 7-bit target address come from strap inputs, so up to four of these blocks can share a bus. Each stored byte is decoded without a register stage into four groups of signals: a low-pass filter speed code, an input-mux select, a bias/power mode, and the enable, mute and filter-valid flags that follow from that mode. Both bus lines are oversampled on a system clock that runs at least eight times the SCL rate.

Top module: `i2c_chan_cfg`

## Requirements
- R1: The target ACKs an address byte whose upper seven bits equal binary 01011 followed by `strap[1]`, `strap[0]` and whose last bit is 0 (write). Any other address byte, including a matching address with the last bit 1, is NACKed, and every later byte up to the next START is NACKed and has no effect.
- R2: A subaddress byte of value 1, 2 or 3 selects channel 0, 1 or 2 and is ACKed. Any other value is NACKed, and the data byte that follows it is NACKed and discarded.
- R3: The first data byte after a valid subaddress is ACKed and written to the selected channel. Any further byte in the same transaction is NACKed and changes nothing.
- R4: The SDA pull-low enable is asserted only for the ninth (acknowledge) SCL pulse of a byte. It changes level only after an SCL falling edge or after a START or STOP.
- R5: `filt_sel` of a channel is 0 for stored bits [7:6] = 00, 1 for 01, and 2 for both 10 and 11.
- R6: `mux_b` of a channel equals stored bit 5 (0 = input A, 1 = input B). Bits [4:3] of a data byte have no effect on any output.
- R7: `bias_mode` of a channel equals stored bits [2:0]. `ch_en` is 0 only for code 000. `ch_mute` is 1 only for code 001.
- R8: `filt_valid` is 1 only for bias codes 101, 110 and 111 (sync-tip clamp). Disabled, muted and clamp modes are mutually exclusive.
- R9: A repeated START aborts the current transaction and restarts address reception. A STOP returns the target to idle with SDA released.
- R10: Reset clears all three channels to 0x00, so every channel reads disabled, muted off, filter code 0 and input A.
- R11: The outputs of a written channel change on the third rising system-clock edge after the SCL falling edge that ends the data byte's eighth bit. This is the same edge on which the data ACK is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | I2C clock line as seen on the bus |
| sda_in | input | 1 | I2C data line as seen on the bus |
| strap | input | 2 | Low address bits taken from the board |
| sda_pull | output | 1 | 1 = drive SDA low (open-drain enable) |
| filt_sel | output | 6 | Per channel, 2 bits: filter speed code 0/1/2 |
| mux_b | output | 3 | Per channel: 1 selects input B |
| bias_mode | output | 9 | Per channel, 3 bits: bias/power mode code |
| ch_en | output | 3 | Per channel: channel powered |
| ch_mute | output | 3 | Per channel: powered but muted |
| filt_valid | output | 3 | Per channel: filter code in use (clamp modes) |

## Verification
Both bus lines pass through two synchronizer flops and one edge register. Any reaction to an SCL edge therefore appears on the third rising clock edge after the bench moves the line. The ACK pull and the register write both land on the third edge after the falling SCL edge that ends the eighth bit, and the pull is released three edges after the ninth falling edge. The bench drives the bus only on falling clock edges. It samples the pull in the middle of each SCL high phase, well clear of those transitions. Its reference model schedules each committed write exactly three rising edges after that SCL fall and compares every decoded output one nanosecond after every rising edge, so an early or late update is caught on the cycle it happens.

// File: rtl/i2c_chcfg_pkg.sv
package i2c_chcfg_pkg;

   localparam int BYTE_W = 8;
   localparam int KEEP_W = 6;   // stored bits: filter(2), mux(1), bias(3)

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_BYTE = 2'd1,
      PH_ACK  = 2'd2
   } phase_t;

   // byte position inside one transaction
   localparam logic [1:0] POS_ADDR  = 2'd0;
   localparam logic [1:0] POS_SUB   = 2'd1;
   localparam logic [1:0] POS_DATA  = 2'd2;
   localparam logic [1:0] POS_EXTRA = 2'd3;

   localparam logic [2:0] BIAS_OFF  = 3'b000;
   localparam logic [2:0] BIAS_MUTE = 3'b001;
   localparam logic [2:0] BIAS_STC0 = 3'b101;

   typedef struct packed {
      logic [1:0] flt;
      logic       mux_b;
      logic [2:0] bias;
      logic       en;
      logic       mute;
      logic       flt_ok;
   } ch_dec_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det,
   output logic sda_lvl
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_sh;
   logic [STAGES-1:0] sda_sh;
   logic              scl_d;
   logic              sda_d;
   logic              scl_s;

   assign scl_s   = scl_sh[STAGES-1];
   assign sda_lvl = sda_sh[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_raw};
         sda_sh <= {sda_sh[STAGES-2:0], sda_raw};
         scl_d  <= scl_s;
         sda_d  <= sda_lvl;
      end
   end

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_lvl;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
   import i2c_chcfg_pkg::*;
#(
   parameter int                 STRAP_W     = 2,
   parameter logic [6-STRAP_W:0] ADDR_PREFIX = 5'b01011,
   parameter int                 NUM_CH      = 3,
   parameter int                 SEL_W       = 2
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start_det,
   input  logic               stop_det,
   input  logic               sda_lvl,
   input  logic [STRAP_W-1:0] strap,
   output logic               sda_pull,
   output logic               wr_en,
   output logic [SEL_W-1:0]   wr_sel,
   output logic [KEEP_W-1:0]  wr_word
);

   generate
      if (STRAP_W < 0 || STRAP_W > 6) begin : g_bad_strap
         $error("i2c_wr_engine: STRAP_W out of range");
      end
      if (NUM_CH < 1 || NUM_CH > 254) begin : g_bad_nch
         $error("i2c_wr_engine: NUM_CH out of range");
      end
   endgenerate

   phase_t             phase;
   logic [BYTE_W-1:0]  shreg;
   logic [3:0]         bitcnt;
   logic [1:0]         pos;
   logic               sub_ok;
   logic [SEL_W-1:0]   sel_q;
   logic               addr_hit;
   logic               sub_hit;
   logic               ack_now;
   logic               byte_done;

   always_comb begin
      addr_hit  = (shreg[7:1] == {ADDR_PREFIX, strap}) && !shreg[0];
      sub_hit   = (shreg != '0) && (int'(shreg) <= NUM_CH);
      unique case (pos)
         POS_ADDR: ack_now = addr_hit;
         POS_SUB:  ack_now = sub_hit;
         POS_DATA: ack_now = sub_ok;
         default:  ack_now = 1'b0;
      endcase
      byte_done = (phase == PH_BYTE) && scl_fall && (bitcnt == 4'd8);
   end

   assign wr_en   = byte_done && (pos == POS_DATA) && sub_ok;
   assign wr_sel  = sel_q;
   assign wr_word = {shreg[7:5], shreg[2:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         shreg    <= '0;
         bitcnt   <= '0;
         pos      <= POS_ADDR;
         sub_ok   <= 1'b0;
         sel_q    <= '0;
         sda_pull <= 1'b0;
      end else if (start_det) begin
         phase    <= PH_BYTE;
         bitcnt   <= '0;
         pos      <= POS_ADDR;
         sub_ok   <= 1'b0;
         sda_pull <= 1'b0;
      end else if (stop_det) begin
         phase    <= PH_IDLE;
         sda_pull <= 1'b0;
      end else begin
         unique case (phase)
            PH_BYTE: begin
               if (scl_rise && bitcnt != 4'd8) begin
                  shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
                  bitcnt <= bitcnt + 4'd1;
               end else if (byte_done) begin
                  sda_pull <= ack_now;
                  phase    <= PH_ACK;
                  if (pos == POS_SUB) begin
                     sub_ok <= sub_hit;
                     sel_q  <= SEL_W'(shreg - 8'd1);
                  end
               end
            end
            PH_ACK: begin
               if (scl_fall) begin
                  sda_pull <= 1'b0;
                  bitcnt   <= '0;
                  phase    <= (pos == POS_ADDR && !sda_pull) ? PH_IDLE : PH_BYTE;
                  if (pos != POS_EXTRA) pos <= pos + 2'd1;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/chan_word_decode.sv
module chan_word_decode
   import i2c_chcfg_pkg::*;
(
   input  logic [KEEP_W-1:0] word,
   output ch_dec_t           dec
);

   always_comb begin
      unique case (word[5:4])
         2'b00:   dec.flt = 2'd0;
         2'b01:   dec.flt = 2'd1;
         default: dec.flt = 2'd2;
      endcase
      dec.mux_b  = word[3];
      dec.bias   = word[2:0];
      dec.en     = (word[2:0] != BIAS_OFF);
      dec.mute   = (word[2:0] == BIAS_MUTE);
      dec.flt_ok = (word[2:0] >= BIAS_STC0);
   end

endmodule

// File: rtl/chan_reg_bank.sv
module chan_reg_bank
   import i2c_chcfg_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int SEL_W  = 2
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [SEL_W-1:0]         wr_sel,
   input  logic [KEEP_W-1:0]        wr_word,
   output ch_dec_t [NUM_CH-1:0]     dec
);

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic [KEEP_W-1:0] word_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                 word_q <= '0;
            else if (wr_en && wr_sel == SEL_W'(ch))     word_q <= wr_word;
         end

         chan_word_decode u_dec (
            .word (word_q),
            .dec  (dec[ch])
         );
      end
   endgenerate

endmodule

// File: rtl/i2c_chan_cfg.sv
module i2c_chan_cfg
   import i2c_chcfg_pkg::*;
#(
   parameter int                 NUM_CH      = 3,
   parameter int                 STRAP_W     = 2,
   parameter logic [6-STRAP_W:0] ADDR_PREFIX = 5'b01011,
   parameter int                 SYNC_STAGES = 2
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_in,
   input  logic                  sda_in,
   input  logic [STRAP_W-1:0]    strap,
   output logic                  sda_pull,
   output logic [2*NUM_CH-1:0]   filt_sel,
   output logic [NUM_CH-1:0]     mux_b,
   output logic [3*NUM_CH-1:0]   bias_mode,
   output logic [NUM_CH-1:0]     ch_en,
   output logic [NUM_CH-1:0]     ch_mute,
   output logic [NUM_CH-1:0]     filt_valid
);

   localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   logic                 scl_rise_evt;
   logic                 scl_fall_evt;
   logic                 start_evt;
   logic                 stop_evt;
   logic                 sda_lvl;
   logic                 commit_evt;
   logic [SEL_W-1:0]     wr_sel;
   logic [KEEP_W-1:0]    wr_word;
   ch_dec_t [NUM_CH-1:0] dec;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_raw   (scl_in),
      .sda_raw   (sda_in),
      .scl_rise  (scl_rise_evt),
      .scl_fall  (scl_fall_evt),
      .start_det (start_evt),
      .stop_det  (stop_evt),
      .sda_lvl   (sda_lvl)
   );

   i2c_wr_engine #(
      .STRAP_W     (STRAP_W),
      .ADDR_PREFIX (ADDR_PREFIX),
      .NUM_CH      (NUM_CH),
      .SEL_W       (SEL_W)
   ) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise_evt),
      .scl_fall  (scl_fall_evt),
      .start_det (start_evt),
      .stop_det  (stop_evt),
      .sda_lvl   (sda_lvl),
      .strap     (strap),
      .sda_pull  (sda_pull),
      .wr_en     (commit_evt),
      .wr_sel    (wr_sel),
      .wr_word   (wr_word)
   );

   chan_reg_bank #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (commit_evt),
      .wr_sel  (wr_sel),
      .wr_word (wr_word),
      .dec     (dec)
   );

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_out
         assign filt_sel[2*g +: 2]  = dec[g].flt;
         assign mux_b[g]            = dec[g].mux_b;
         assign bias_mode[3*g +: 3] = dec[g].bias;
         assign ch_en[g]            = dec[g].en;
         assign ch_mute[g]          = dec[g].mute;
         assign filt_valid[g]       = dec[g].flt_ok;
      end
   endgenerate

endmodule

// File: rtl/i2c_chan_cfg_chk.sv
module i2c_chan_cfg_chk #(
   parameter int NUM_CH = 3
)(
   input logic                clk,
   input logic                rst_n,
   input logic                sda_pull,
   input logic                scl_fall_evt,
   input logic                start_evt,
   input logic                stop_evt,
   input logic                commit_evt,
   input logic [2*NUM_CH-1:0] filt_sel,
   input logic [NUM_CH-1:0]   mux_b,
   input logic [3*NUM_CH-1:0] bias_mode,
   input logic [NUM_CH-1:0]   ch_en,
   input logic [NUM_CH-1:0]   ch_mute,
   input logic [NUM_CH-1:0]   filt_valid
);

   logic commits_in_txn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          commits_in_txn <= 1'b0;
      else if (start_evt)  commits_in_txn <= 1'b0;
      else if (commit_evt) commits_in_txn <= 1'b1;
   end

   // R4: the pull only moves after an SCL fall or a START/STOP
   a_r4_pull_moves_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> $past(scl_fall_evt || start_evt || stop_evt));

   // R9: STOP leaves SDA released
   a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_pull);

   // R3: at most one register write between two STARTs
   a_r3_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
      commit_evt |-> !commits_in_txn);

   // R11: decoded outputs move only on the edge that performs a write
   a_r11_outputs_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({filt_sel, mux_b, bias_mode}) |-> $past(commit_evt));

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
         // R8: disabled, muted and clamp modes exclude each other
         a_r8_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({!ch_en[g], ch_mute[g], filt_valid[g]}));
      end
   endgenerate

endmodule

bind i2c_chan_cfg i2c_chan_cfg_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sda_pull     (sda_pull),
   .scl_fall_evt (scl_fall_evt),
   .start_evt    (start_evt),
   .stop_evt     (stop_evt),
   .commit_evt   (commit_evt),
   .filt_sel     (filt_sel),
   .mux_b        (mux_b),
   .bias_mode    (bias_mode),
   .ch_en        (ch_en),
   .ch_mute      (ch_mute),
   .filt_valid   (filt_valid)
);

// File: tb/i2c_chan_cfg_tb_top.sv
`timescale 1ns/1ps
module i2c_chan_cfg_tb_top;

   localparam int   Q      = 8;            // system clocks per quarter SCL bit
   localparam [1:0] STRAP  = 2'b10;
   localparam [7:0] A_WR   = {5'b01011, STRAP, 1'b0};
   localparam [7:0] A_RD   = {5'b01011, STRAP, 1'b1};
   localparam [7:0] A_BAD  = {5'b01011, 2'b01, 1'b0};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_pull;
   logic [5:0] filt_sel;
   logic [2:0] mux_b, ch_en, ch_mute, filt_valid;
   logic [8:0] bias_mode;
   wire        sda_bus = sda_m & ~sda_pull;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference model state
   logic [7:0] exp_reg [3];
   int  m_pos;
   bit  m_addr_ok, m_sub_ok;
   int  m_ch;

   always #2 clk = ~clk;

   i2c_chan_cfg dut_i (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .strap(STRAP),
      .sda_pull(sda_pull), .filt_sel(filt_sel), .mux_b(mux_b), .bias_mode(bias_mode),
      .ch_en(ch_en), .ch_mute(ch_mute), .filt_valid(filt_valid)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic [1:0] e_flt(input [7:0] w);
      if (w[7:6] == 2'b00) return 2'd0;
      if (w[7:6] == 2'b01) return 2'd1;
      return 2'd2;
   endfunction

   // per-clock comparison of every decoded output against the model
   always @(posedge clk) begin
      #1;
      if (!done) begin
         logic [5:0] xf; logic [2:0] xm, xe, xu, xv; logic [8:0] xb;
         for (int c = 0; c < 3; c++) begin
            xf[2*c +: 2] = e_flt(exp_reg[c]);
            xm[c]        = exp_reg[c][5];
            xb[3*c +: 3] = exp_reg[c][2:0];
            xe[c]        = exp_reg[c][2:0] != 3'd0;
            xu[c]        = exp_reg[c][2:0] == 3'd1;
            xv[c]        = exp_reg[c][2:0] >= 3'd5;
         end
         check("R5/R11 filt_sel", filt_sel, xf);
         check("R6/R11 mux_b", mux_b, xm);
         check("R7/R11 bias/en/mute", {bias_mode, ch_en, ch_mute}, {xb, xe, xu});
         check("R8/R11 filt_valid", filt_valid, xv);
      end
   end

   task automatic qw();
      repeat (Q) @(negedge clk);
   endtask

   task automatic m_restart();
      m_pos = 0; m_addr_ok = 0; m_sub_ok = 0;
   endtask

   task automatic i2c_start();
      sda_m = 1'b1; scl = 1'b1; qw();
      sda_m = 1'b0; qw();
      scl = 1'b0;
      m_restart();
   endtask

   task automatic i2c_rstart();
      qw(); sda_m = 1'b1; qw();
      scl = 1'b1; qw();
      sda_m = 1'b0; qw();
      scl = 1'b0;
      m_restart();
   endtask

   task automatic i2c_stop();
      qw(); sda_m = 1'b0; qw();
      scl = 1'b1; qw();
      sda_m = 1'b1; qw();
      check("R9 released after stop", sda_pull, 0);
   endtask

   task automatic send_byte(input [7:0] b, input string tag);
      bit ack;
      for (int i = 7; i >= 0; i--) begin
         qw(); sda_m = b[i]; qw();
         scl = 1'b1; qw();
         check("R4 no pull in data bit", sda_pull, 0);
         qw(); scl = 1'b0;
      end
      // model decision at the falling edge that ends bit eight
      ack = 1'b0;
      if (m_pos == 0) begin
         ack = (b[7:1] == {5'b01011, STRAP}) && !b[0];
         m_addr_ok = ack;
      end else if (m_pos == 1) begin
         ack = m_addr_ok && b >= 8'd1 && b <= 8'd3;
         m_sub_ok = ack;
         m_ch = int'(b) - 1;
      end else if (m_pos == 2) begin
         ack = m_addr_ok && m_sub_ok;
         if (ack) begin
            automatic int ch = m_ch;
            automatic logic [7:0] v = b;
            fork
               begin repeat (3) @(posedge clk); exp_reg[ch] = v; end
            join_none
         end
      end
      m_pos++;
      qw(); sda_m = 1'b1; qw();
      scl = 1'b1; qw();
      check(tag, sda_pull, ack);
      qw(); scl = 1'b0;
   endtask

   task automatic write3(input [7:0] a, input [7:0] s, input [7:0] d);
      i2c_start();
      send_byte(a, "R1 address ack");
      send_byte(s, "R2 subaddress ack");
      send_byte(d, "R3 data ack");
      i2c_stop();
   endtask

   initial begin
      repeat (10) @(posedge clk);
      while (!done) @(posedge clk);
   end

   initial begin
      for (int c = 0; c < 3; c++) exp_reg[c] = 8'h00;
      m_restart(); m_ch = 0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R10 reset ch_en", ch_en, 0);
      check("R10 reset bias_mode", bias_mode, 0);
      check("R10 reset filt/mux", {filt_sel, mux_b}, 0);
      check("R10 reset pull", sda_pull, 0);

      write3(A_WR, 8'h01, 8'b10_1_11_111);      // ch0: fast, B, clamp high
      write3(A_WR, 8'h02, 8'b11_0_00_101);      // ch1: 11 aliases fast, clamp low
      write3(A_WR, 8'h03, 8'b00_1_00_110);      // ch2: slow, clamp mid
      check("R5 fast alias 11", filt_sel[3:2], 2);
      write3(A_WR, 8'h01, 8'b01_0_00_010);      // ch0: DC bias, filter unused
      check("R8 no filt_valid in DC", filt_valid[0], 0);

      write3(A_BAD, 8'h02, 8'h01);              // R1 wrong strap: all NACK
      write3(A_RD, 8'h02, 8'h01);               // R1 read bit: all NACK
      check("R1 no change after nack", bias_mode[5:3], 3'b101);

      write3(A_WR, 8'h00, 8'h03);               // R2 bad subaddress 0
      write3(A_WR, 8'h04, 8'h03);               // R2 bad subaddress 4
      check("R2 discarded data", {bias_mode}, {3'b110, 3'b101, 3'b010});

      // R3 extra byte NACKed and dropped
      i2c_start();
      send_byte(A_WR, "R1 address ack");
      send_byte(8'h02, "R2 subaddress ack");
      send_byte(8'b00_0_00_001, "R3 data ack");
      send_byte(8'b00_0_00_100, "R3 extra byte nack");
      i2c_stop();
      check("R3 only first byte kept", ch_mute[1], 1);

      // R9 repeated START restarts address reception
      i2c_start();
      send_byte(A_WR, "R1 address ack");
      send_byte(8'h03, "R2 subaddress ack");
      i2c_rstart();
      send_byte(A_WR, "R9 address after rstart");
      send_byte(8'h01, "R2 subaddress ack");
      send_byte(8'b00_0_00_100, "R3 data ack");
      i2c_stop();
      check("R9 ch2 untouched", bias_mode[8:6], 3'b110);
      check("R7 AC bias on ch0", {ch_en[0], bias_mode[2:0]}, {1'b1, 3'b100});

      // R6 reserved bits: same word with bits 4:3 flipped
      write3(A_WR, 8'h03, 8'b00_1_11_110);
      check("R6 reserved bits no effect", {filt_sel[5:4], mux_b[2], bias_mode[8:6]},
            {2'd0, 1'b1, 3'b110});
      write3(A_WR, 8'h03, 8'b00_0_00_011);       // DC plus offset
      write3(A_WR, 8'h02, 8'b00_0_00_000);       // disable
      check("R7 disabled ch1", ch_en[1], 0);
      check("R7 DC offset ch2", {ch_en[2], ch_mute[2]}, 2'b10);

      repeat (20) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule